// File: doc/BRIEF.md
# Grouped Interrupt Expander

This block gathers up to 96 peripheral interrupt request lines, arranged as 12 groups of 8 sources. Each group has one interrupt line toward the CPU. Each source has a flag bit and an enable bit in its group. Each group also has an acknowledge bit. A rising edge on a source line sets its flag. The group raises its CPU line when a flagged source is also enabled and the group's acknowledge bit is clear. When the block issues a request, it sets that acknowledge bit in the same step, so each group has at most one request outstanding. Software writes 1 to the acknowledge bit to let the next request through.

When the CPU services a group, it names the group and the source it chose. The block offers the lowest-numbered source that is both flagged and enabled as that choice, and clears that flag. A small register port lets software read and write the flags, enables and acknowledges. A few further interrupt lines go straight to the CPU without any gating.

Top module: `irq_expander`

## Requirements
- R1: After reset, every flag, enable and acknowledge bit reads 0 and no CPU line is high.
- R2: A rising edge on source line y of group x sets flag bit y of group x whether or not that source is enabled. Group x uses source lines 8x to 8x+7, and bit y of each group register belongs to line 8x+y. A line that stays high sets its flag only once, so after software clears the flag it stays clear.
- R3: When a group has a flagged and enabled source and its acknowledge bit is clear, the group's CPU line gives a pulse one cycle wide. In the same cycle the acknowledge bit becomes 1. The pulse comes two clock edges after the source's rising edge.
- R4: A flagged source that is disabled causes no pulse. If its enable bit is set later while the flag is still set, a pulse follows.
- R5: While a group's acknowledge bit is 1, no further pulse comes from that group. Writing 1 to the acknowledge bit clears it, and a request that is still pending then pulses.
- R6: Writing 0 to an acknowledge bit has no effect.
- R7: A service input with valid high, a group and a source index clears that flag bit. The selection output shows the lowest-indexed source of the named group that is both flagged and enabled, or 0 if there is none.
- R8: If a software write to a flag register and a rising edge on one of its sources happen in the same cycle, the bit for that source ends up set.
- R9: The direct interrupt inputs appear on the direct outputs unchanged and in the same cycle.
- R10: The register address is group*4 + kind. Kind 0 is flags, kind 1 is enables, and kind 2 is acknowledge, held in bit 0. Reads are combinational. An address whose group is 12 or more, or whose kind is 3, reads 0 and ignores writes.
- R11: A flag, enable, acknowledge or service action on one group does not change any other group's state or CPU line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 96 | Source request lines; group x uses bits 8x..8x+7 |
| direct_i | input | 4 | Interrupt lines that bypass the groups |
| direct_o | output | 4 | Copy of direct_i for the CPU |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address {group, kind} |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| svc_valid_i | input | 1 | CPU service strobe |
| svc_group_i | input | 4 | Group being serviced |
| svc_src_i | input | 3 | Source being serviced; its flag is cleared |
| svc_sel_o | output | 3 | Lowest flagged and enabled source of svc_group_i |
| cpu_irq_o | output | 12 | One pulse line per group toward the CPU |

## Verification
Directed patterns cover several cases. A single edge on an enabled source shows the path from edge to pulse. A second edge while the acknowledge bit is set shows that the bit holds the request back. A disabled source that is enabled later separates flag capture from request generation. A held line and a software clear show edge detection, and a software write that lands in the same cycle as an edge shows which one wins. A random phase then mixes edges, register writes and service strobes across all groups. A behavioural model of the flag, enable and acknowledge state is compared with the CPU lines, read data, selection and direct outputs on every cycle, which exposes cross-group leakage and ordering errors.

// File: rtl/irq_exp_pkg.sv
package irq_exp_pkg;
  localparam int unsigned KIND_W = 2;
  typedef enum logic [KIND_W-1:0] {
    REG_FLAG = 2'd0,
    REG_EN   = 2'd1,
    REG_ACK  = 2'd2,
    REG_NONE = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [W-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int unsigned SRC   = 8,
  parameter int unsigned SRC_W = $clog2(SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC-1:0]   rise_i,
  input  logic             flag_we_i,
  input  logic             en_we_i,
  input  logic             ack_we_i,
  input  logic [SRC-1:0]   wdata_i,
  input  logic             svc_i,
  input  logic [SRC_W-1:0] svc_src_i,
  output logic [SRC-1:0]   flag_o,
  output logic [SRC-1:0]   en_o,
  output logic             ack_o,
  output logic             irq_o,
  output logic [SRC_W-1:0] sel_o
);
  logic [SRC-1:0] flag_q, flag_d, en_q;
  logic           ack_q, irq_q, any_req, issue;

  irq_prio_sel #(.W(SRC), .IDX_W(SRC_W)) u_sel (
    .req_i (flag_q & en_q),
    .idx_o (sel_o),
    .any_o (any_req)
  );

  assign issue = any_req & ~ack_q;

  always_comb begin
    flag_d = flag_q;
    if (flag_we_i) flag_d = wdata_i;
    if (svc_i)     flag_d[svc_src_i] = 1'b0;
    flag_d = flag_d | rise_i; // new edge beats any clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= issue;
      if (en_we_i) en_q <= wdata_i;
      if (issue)                       ack_q <= 1'b1;
      else if (ack_we_i && wdata_i[0]) ack_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign ack_o  = ack_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irq_expander.sv
module irq_expander
  import irq_exp_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 12,
  parameter int unsigned GROUP_SRCS = 8,
  parameter int unsigned NUM_DIRECT = 4,
  localparam int unsigned GRP_W  = $clog2(NUM_GROUPS),
  localparam int unsigned SRC_W  = $clog2(GROUP_SRCS),
  localparam int unsigned ADDR_W = GRP_W + KIND_W,
  localparam int unsigned NSRC   = NUM_GROUPS * GROUP_SRCS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NSRC-1:0]       src_i,
  input  logic [NUM_DIRECT-1:0] direct_i,
  output logic [NUM_DIRECT-1:0] direct_o,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [GROUP_SRCS-1:0] reg_wdata_i,
  output logic [GROUP_SRCS-1:0] reg_rdata_o,
  input  logic                  svc_valid_i,
  input  logic [GRP_W-1:0]      svc_group_i,
  input  logic [SRC_W-1:0]      svc_src_i,
  output logic [SRC_W-1:0]      svc_sel_o,
  output logic [NUM_GROUPS-1:0] cpu_irq_o
);
  logic [NSRC-1:0]       rise;
  logic [GRP_W-1:0]      addr_grp;
  reg_kind_e             addr_kind;
  logic                  addr_ok, svc_ok;
  logic [GROUP_SRCS-1:0] flag_arr [NUM_GROUPS];
  logic [GROUP_SRCS-1:0] en_arr   [NUM_GROUPS];
  logic [SRC_W-1:0]      sel_arr  [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] ack_all;
  logic [NSRC-1:0]       flag_all, en_all;

  assign direct_o  = direct_i;
  assign addr_grp  = reg_addr_i[ADDR_W-1:KIND_W];
  assign addr_kind = reg_kind_e'(reg_addr_i[KIND_W-1:0]);
  assign addr_ok   = (int'(addr_grp) < NUM_GROUPS);
  assign svc_ok    = (int'(svc_group_i) < NUM_GROUPS);

  irq_edge_det #(.W(NSRC)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (src_i),
    .rise_o (rise)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = reg_we_i && addr_ok && (addr_grp == GRP_W'(g));

    irq_group #(.SRC(GROUP_SRCS), .SRC_W(SRC_W)) u_group (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_i    (rise[g*GROUP_SRCS +: GROUP_SRCS]),
      .flag_we_i (hit && addr_kind == REG_FLAG),
      .en_we_i   (hit && addr_kind == REG_EN),
      .ack_we_i  (hit && addr_kind == REG_ACK),
      .wdata_i   (reg_wdata_i),
      .svc_i     (svc_valid_i && svc_group_i == GRP_W'(g)),
      .svc_src_i (svc_src_i),
      .flag_o    (flag_arr[g]),
      .en_o      (en_arr[g]),
      .ack_o     (ack_all[g]),
      .irq_o     (cpu_irq_o[g]),
      .sel_o     (sel_arr[g])
    );

    assign flag_all[g*GROUP_SRCS +: GROUP_SRCS] = flag_arr[g];
    assign en_all[g*GROUP_SRCS +: GROUP_SRCS]   = en_arr[g];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (addr_ok) begin
      case (addr_kind)
        REG_FLAG: reg_rdata_o = flag_arr[addr_grp];
        REG_EN:   reg_rdata_o = en_arr[addr_grp];
        REG_ACK:  reg_rdata_o = {{(GROUP_SRCS-1){1'b0}}, ack_all[addr_grp]};
        default:  reg_rdata_o = '0;
      endcase
    end
  end

  assign svc_sel_o = svc_ok ? sel_arr[svc_group_i] : '0;
endmodule

// File: rtl/irq_expander_chk.sv
module irq_expander_chk #(
  parameter int unsigned NUM_GROUPS = 12,
  parameter int unsigned GROUP_SRCS = 8,
  localparam int unsigned NSRC = NUM_GROUPS * GROUP_SRCS
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NSRC-1:0]       src_i,
  input logic [NUM_GROUPS-1:0] cpu_irq_o,
  input logic [NSRC-1:0]       flag_all,
  input logic [NSRC-1:0]       en_all,
  input logic [NUM_GROUPS-1:0] ack_all
);
  logic [NSRC-1:0] src_d, rise_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_d  <= '0;
      rise_d <= '0;
    end else begin
      src_d  <= src_i;
      rise_d <= src_i & ~src_d;
    end
  end

  a_r2_rise_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_d & ~flag_all) == '0);

  a_r3_one_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_irq_o & $past(cpu_irq_o)) == '0);

  a_r3_issue_sets_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_irq_o & ~ack_all) == '0);

  a_r5_ack_holds_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_irq_o & $past(ack_all)) == '0);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    a_r4_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cpu_irq_o[g] |-> $past(|(flag_all[g*GROUP_SRCS +: GROUP_SRCS] &
                               en_all[g*GROUP_SRCS +: GROUP_SRCS])));
  end
endmodule

bind irq_expander irq_expander_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .GROUP_SRCS (GROUP_SRCS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_i     (src_i),
  .cpu_irq_o (cpu_irq_o),
  .flag_all  (flag_all),
  .en_all    (en_all),
  .ack_all   (ack_all)
);

// File: tb/irq_expander_tb.sv
module irq_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int G = 12;
  localparam int S = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [95:0]  src_i = '0;
  logic [D-1:0] direct_i = '0;
  logic [D-1:0] direct_o;
  logic         reg_we_i = 1'b0;
  logic [5:0]   reg_addr_i = '0;
  logic [7:0]   reg_wdata_i = '0;
  logic [7:0]   reg_rdata_o;
  logic         svc_valid_i = 1'b0;
  logic [3:0]   svc_group_i = '0;
  logic [2:0]   svc_src_i = '0;
  logic [2:0]   svc_sel_o;
  logic [G-1:0] cpu_irq_o;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int cnt [G];

  // reference state
  logic [7:0]   m_flag [G];
  logic [7:0]   m_en   [G];
  logic [G-1:0] m_ack, m_irq;
  logic [95:0]  m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_expander u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .src_i (src_i),
    .direct_i (direct_i), .direct_o (direct_o),
    .reg_we_i (reg_we_i), .reg_addr_i (reg_addr_i),
    .reg_wdata_i (reg_wdata_i), .reg_rdata_o (reg_rdata_o),
    .svc_valid_i (svc_valid_i), .svc_group_i (svc_group_i),
    .svc_src_i (svc_src_i), .svc_sel_o (svc_sel_o),
    .cpu_irq_o (cpu_irq_o)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < G; g++) begin m_flag[g] = '0; m_en[g] = '0; end
      m_ack = '0; m_irq = '0; m_prev = '0;
    end else begin
      for (int g = 0; g < G; g++) begin
        logic [7:0] nf;
        logic       pend, wr;
        pend = ((m_flag[g] & m_en[g]) != 0) && !m_ack[g];
        wr   = reg_we_i && (int'(reg_addr_i >> 2) == g);
        nf   = m_flag[g];
        if (wr && reg_addr_i[1:0] == 2'd0) nf = reg_wdata_i;
        if (svc_valid_i && int'(svc_group_i) == g) nf[svc_src_i] = 1'b0;
        nf = nf | (src_i[g*S +: S] & ~m_prev[g*S +: S]);
        if (wr && reg_addr_i[1:0] == 2'd1) m_en[g] = reg_wdata_i;
        if (pend) m_ack[g] = 1'b1;
        else if (wr && reg_addr_i[1:0] == 2'd2 && reg_wdata_i[0]) m_ack[g] = 1'b0;
        m_irq[g]  = pend;
        m_flag[g] = nf;
      end
      m_prev = src_i;
    end
  end

  function automatic logic [7:0] exp_rdata();
    int grp = int'(reg_addr_i >> 2);
    if (grp >= G) return 8'h00;
    case (reg_addr_i[1:0])
      2'd0: return m_flag[grp];
      2'd1: return m_en[grp];
      2'd2: return {7'b0, m_ack[grp]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [2:0] exp_sel();
    if (int'(svc_group_i) >= G) return 3'd0;
    for (int i = 0; i < S; i++)
      if (m_flag[svc_group_i][i] && m_en[svc_group_i][i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle compare against the model
  always @(negedge clk) begin
    #2;
    if (rst_ni) begin
      for (int g = 0; g < G; g++) if (cpu_irq_o[g]) cnt[g]++;
      chk(cpu_irq_o == m_irq, "R3 cpu_irq", int'(cpu_irq_o), int'(m_irq));
      chk(reg_rdata_o == exp_rdata(), "R10 rdata", int'(reg_rdata_o), int'(exp_rdata()));
      chk(svc_sel_o == exp_sel(), "R7 sel", int'(svc_sel_o), int'(exp_sel()));
      chk(direct_o == direct_i, "R9 direct", int'(direct_o), int'(direct_i));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int grp, input int kind, input logic [7:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 6'(grp * 4 + kind); reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int grp, input int kind, output logic [7:0] v);
    @(negedge clk);
    reg_addr_i = 6'(grp * 4 + kind);
    #2 v = reg_rdata_o;
  endtask

  task automatic svc(input int grp, input int s);
    @(negedge clk);
    svc_valid_i = 1'b1; svc_group_i = 4'(grp); svc_src_i = 3'(s);
    @(negedge clk);
    svc_valid_i = 1'b0;
  endtask

  task automatic pulse_src(input int idx);
    @(negedge clk); src_i[idx] = 1'b1;
    @(negedge clk); src_i[idx] = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    for (int g = 0; g < G; g++) cnt[g] = 0;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1
    rd(0, 0, v);  chk(v == 0, "R1 flag reset", v, 0);
    rd(11, 1, v); chk(v == 0, "R1 en reset", v, 0);
    rd(5, 2, v);  chk(v == 0, "R1 ack reset", v, 0);
    chk(cpu_irq_o == 0, "R1 irq reset", int'(cpu_irq_o), 0);

    // R3: enabled edge -> one pulse, ack set
    wr(0, 1, 8'h24);
    pulse_src(5);
    idle(3);
    chk(cnt[0] == 1, "R3 pulse count", cnt[0], 1);
    rd(0, 2, v); chk(v == 1, "R3 ack set", v, 1);
    @(negedge clk); svc_group_i = 4'd0;
    #2 chk(svc_sel_o == 3'd5, "R7 sel single", int'(svc_sel_o), 5);

    // R5: second edge held back by ack
    pulse_src(2);
    idle(3);
    chk(cnt[0] == 1, "R5 held back", cnt[0], 1);
    @(negedge clk); #2 chk(svc_sel_o == 3'd2, "R7 sel lowest", int'(svc_sel_o), 2);
    svc(0, 5);
    rd(0, 0, v); chk(v == 8'h04, "R7 svc clears flag", v, 8'h04);
    @(negedge clk); svc_group_i = 4'd0;
    #2 chk(svc_sel_o == 3'd2, "R7 sel after svc", int'(svc_sel_o), 2);
    // R6
    wr(0, 2, 8'h00);
    idle(3);
    rd(0, 2, v); chk(v == 1, "R6 ack write 0 ignored", v, 1);
    chk(cnt[0] == 1, "R6 no pulse", cnt[0], 1);
    // R5 release
    wr(0, 2, 8'h01);
    idle(3);
    chk(cnt[0] == 2, "R5 released pulse", cnt[0], 2);
    svc(0, 2);
    wr(0, 2, 8'h01);
    idle(3);
    rd(0, 2, v); chk(v == 0, "R5 ack cleared idle", v, 0);
    chk(cnt[0] == 2, "R5 no spurious pulse", cnt[0], 2);

    // R4: disabled source then enabled later (group 1, bit 0 = line 8)
    pulse_src(8);
    idle(3);
    rd(1, 0, v); chk(v == 8'h01, "R2 flag without enable", v, 1);
    chk(cnt[1] == 0, "R4 disabled no pulse", cnt[1], 0);
    wr(1, 1, 8'h01);
    idle(3);
    chk(cnt[1] == 1, "R4 late enable pulse", cnt[1], 1);
    chk(cnt[0] == 2, "R11 other group untouched", cnt[0], 2);
    rd(0, 1, v); chk(v == 8'h24, "R11 other enable intact", v, 8'h24);

    // R2: held line sets once
    @(negedge clk); src_i[9] = 1'b1;
    idle(2);
    wr(1, 0, 8'h00);
    idle(3);
    rd(1, 0, v); chk(v == 0, "R2 held line no reflag", v, 0);
    @(negedge clk); src_i[9] = 1'b0;

    // R8: write and edge in the same cycle
    @(negedge clk);
    src_i[10] = 1'b1; reg_we_i = 1'b1; reg_addr_i = 6'(1 * 4 + 0); reg_wdata_i = 8'h00;
    @(negedge clk);
    reg_we_i = 1'b0; src_i[10] = 1'b0;
    rd(1, 0, v); chk(v == 8'h04, "R8 edge beats clear", v, 8'h04);

    // R9
    @(negedge clk); direct_i = 4'b1010;
    #2 chk(direct_o == 4'b1010, "R9 passthrough", int'(direct_o), 10);

    // R10: out-of-range group and kind 3
    wr(12, 1, 8'hFF);
    rd(12, 1, v); chk(v == 0, "R10 bad group", v, 0);
    wr(2, 3, 8'hFF);
    rd(2, 3, v); chk(v == 0, "R10 kind 3", v, 0);
    rd(2, 1, v); chk(v == 0, "R10 kind 3 no side write", v, 0);

    // random mix, model compared every cycle
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      src_i       = src_i ^ {$urandom, $urandom, $urandom} & {3{$urandom}};
      direct_i    = 4'($urandom);
      reg_we_i    = ($urandom % 4) == 0;
      reg_addr_i  = 6'(($urandom % 13) * 4 + ($urandom % 4));
      reg_wdata_i = 8'($urandom);
      svc_valid_i = ($urandom % 5) == 0;
      svc_group_i = 4'($urandom % 12);
      svc_src_i   = 3'($urandom);
    end
    @(negedge clk);
    reg_we_i = 1'b0; svc_valid_i = 1'b0;
    idle(4);
    done = 1;
    summary();
    $finish;
  end
endmodule